// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

The block gathers interrupt requests from external hardware lines, from each CPU's private timer and watchdog, and from software, and presents them to up to four CPUs. Every interrupt ID has its own state on every CPU: inactive, pending or active. For each CPU the block picks the most urgent pending, enabled interrupt, raises that CPU's `irq` output, and lets the CPU take and complete interrupts through a small acknowledge and end-of-interrupt interface.

Configuration goes through a write-only register port. Each write carries the number of the CPU that issues it. That number selects the per-CPU copy of enable and priority for IDs below 32. It also serves as the sender of a software interrupt. Software interrupts can go to a chosen set of CPUs, to every CPU but the sender, or to the sender alone. Each target CPU uses its own priority for the software interrupt.

ID layout: IDs 0 to 15 are software interrupts. ID 29 is the private timer and ID 30 the private watchdog. IDs from 32 upward are hardware lines, with line `k` mapped to ID `32+k`. All other IDs are not implemented. Register writes use `reg_addr` as follows:
- 0 sets enable: `wdata[9:0]` is the ID and `wdata[31]` is the enable bit.
- 1 sets priority: `wdata[19:16]` is the priority.
- 2 sets the CPU target mask of a hardware ID: `wdata[19:16]` is the mask, with bit c meaning CPU c.
- 3 issues a software interrupt: `wdata[3:0]` is the ID, `wdata[25:24]` is the mode (0 = the listed set, 1 = all but the sender, 2 = the sender only, 3 = ignored), and `wdata[19:16]` is the list.
- 4 sets the writing CPU's priority mask from `wdata[3:0]`.

Top module: `idc_distributor`

## Requirements
- R1: After reset every `irq` output is low. Every ID is inactive and disabled, and an acknowledge on any CPU returns 1023.
- R2: An enabled hardware ID whose line is high becomes pending, and raises `irq`, on exactly the CPUs whose bits are set in its target mask.
- R3: A software interrupt write sets the ID pending on the CPUs the mode selects: mode 0 uses the list, mode 1 uses all CPUs but the sender, and mode 2 uses the sender only. Mode 3 has no effect.
- R4: A software interrupt is judged on each target CPU with that CPU's own enable and priority for the ID. The sender's settings play no part.
- R5: Among the interrupts that qualify, the lowest priority value wins. A tie goes to the lowest ID.
- R6: An interrupt is signalled to a CPU only if its priority value is strictly below that CPU's mask. A mask of 0 blocks everything, and an acknowledge with nothing signalled returns 1023.
- R7: An acknowledge pulse on CPU c makes `ack_id` of c show the winning ID one clock later. The winning ID moves from pending to active on that CPU only.
- R8: While interrupts are active on a CPU, a pending interrupt is signalled only if its priority value is strictly below the lowest value among the active ones.
- R9: An end-of-interrupt for an active ID returns it to inactive on the issuing CPU only. The running priority then falls back to what the remaining active interrupts give.
- R10: A level source that drops while pending returns to inactive. A level source still high after end-of-interrupt becomes pending again on the next clock.
- R11: The timer input and the watchdog input of CPU c drive IDs 29 and 30 on CPU c alone.
- R12: Enable bits for IDs below 32 are kept per CPU. A disabled pending interrupt is not signalled, and it is signalled as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_cpu | input | CPU_W | Number of the writing CPU |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| hw_irq | input | NUM_HW | Level hardware lines, line k is ID 32+k |
| timer_irq | input | NCPU | Per-CPU private timer level (ID 29) |
| wdog_irq | input | NCPU | Per-CPU private watchdog level (ID 30) |
| ack_req | input | NCPU | Per-CPU acknowledge pulse |
| eoi_req | input | NCPU | Per-CPU end-of-interrupt pulse |
| eoi_id | input | NCPU*10 | Per-CPU ID being completed |
| irq | output | NCPU | Per-CPU interrupt request |
| ack_id | output | NCPU*10 | Per-CPU acknowledged ID, 1023 if none |

## Verification
The bench targets the following cases, and the failure each would show:
- Priority ties between hardware IDs: a design that scans from the wrong end returns the higher ID.
- Equal-priority pending behind an active interrupt: a non-strict preemption compare raises `irq` when it must stay low.
- Nested completion: a stale running priority after the inner end-of-interrupt either hides or wrongly releases the outer level.
- The three software interrupt modes plus the ignored one: a mixed-up mode decode reaches the wrong CPU set.
- Software interrupt priority: a design that uses the sender's priority lets the blocked target through.
- Per-CPU completion of a shared hardware line: shared instead of per-CPU state would wrongly clear or re-pend the other CPU.

// File: rtl/idc_pkg.sv
package idc_pkg;
   localparam int ID_W      = 10;
   localparam int PRIO_W    = 4;
   localparam int SGI_NUM   = 16;
   localparam int ID_TIMER  = 29;
   localparam int ID_WDOG   = 30;
   localparam int HW_BASE   = 32;
   localparam int HW_MAX    = 224;
   localparam int NO_IRQ    = 1023;

   localparam logic [1:0] ST_INACT = 2'd0;
   localparam logic [1:0] ST_PEND  = 2'd1;
   localparam logic [1:0] ST_ACT   = 2'd2;

   localparam logic [2:0] RA_ENABLE = 3'd0;
   localparam logic [2:0] RA_PRIO   = 3'd1;
   localparam logic [2:0] RA_TARGET = 3'd2;
   localparam logic [2:0] RA_SOFT   = 3'd3;
   localparam logic [2:0] RA_MASK   = 3'd4;

   localparam logic [1:0] SM_LIST   = 2'd0;
   localparam logic [1:0] SM_OTHERS = 2'd1;
   localparam logic [1:0] SM_SELF   = 2'd2;

   function automatic bit id_used(input int id, input int nhw);
      return (id < SGI_NUM) || (id == ID_TIMER) || (id == ID_WDOG) ||
             ((id >= HW_BASE) && (id < HW_BASE + nhw));
   endfunction

   function automatic bit id_banked(input int id);
      return id < HW_BASE;
   endfunction
endpackage

// File: rtl/idc_cfg_regs.sv
module idc_cfg_regs #(
   parameter int NCPU   = 4,
   parameter int NUM_HW = 8,
   parameter int CPU_W  = 2,
   localparam int NID   = idc_pkg::HW_BASE + NUM_HW,
   localparam int IDW   = idc_pkg::ID_W,
   localparam int PW    = idc_pkg::PRIO_W
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr,
   input  logic [CPU_W-1:0]                       wr_cpu,
   input  logic [2:0]                             wr_addr,
   input  logic [31:0]                            wr_data,
   output logic [NCPU-1:0][NID-1:0]               en_o,
   output logic [NCPU-1:0][NID-1:0][PW-1:0]       prio_o,
   output logic [NUM_HW-1:0][NCPU-1:0]            tgt_o,
   output logic [NCPU-1:0][PW-1:0]                mask_o,
   output logic [NCPU-1:0][idc_pkg::SGI_NUM-1:0]  sgi_set_o
);
   import idc_pkg::*;

   logic [IDW-1:0]  wid;
   logic [3:0]      field4;
   logic [1:0]      smode;
   logic [NCPU-1:0] self_m;
   logic [NCPU-1:0] dest_m;
   logic            unused_bits;

   assign wid         = wr_data[IDW-1:0];
   assign field4      = wr_data[19:16];
   assign smode       = wr_data[25:24];
   assign unused_bits = ^{wr_data[15:10], wr_data[23:20], wr_data[30:26]};

   // per-ID enable and priority, banked per CPU below the hardware range
   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      for (genvar i = 0; i < NID; i++) begin : g_id
         if (id_used(i, NUM_HW)) begin : g_live
            logic sel;
            if (id_banked(i)) begin : g_bank
               assign sel = (wid == IDW'(i)) && (wr_cpu == CPU_W'(c));
            end else begin : g_shared
               assign sel = (wid == IDW'(i));
            end
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  en_o[c][i]   <= 1'b0;
                  prio_o[c][i] <= '0;
               end else if (wr && sel) begin
                  if (wr_addr == RA_ENABLE) en_o[c][i]   <= wr_data[31];
                  if (wr_addr == RA_PRIO)   prio_o[c][i] <= field4[PW-1:0];
               end
            end
         end else begin : g_dead
            assign en_o[c][i]   = 1'b0;
            assign prio_o[c][i] = '0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_o[c] <= '0;
         else if (wr && wr_addr == RA_MASK && wr_cpu == CPU_W'(c))
            mask_o[c] <= wr_data[PW-1:0];
      end
   end

   for (genvar h = 0; h < NUM_HW; h++) begin : g_tgt
      always_ff @(posedge clk) begin
         if (!rst_n)
            tgt_o[h] <= '0;
         else if (wr && wr_addr == RA_TARGET && wid == IDW'(HW_BASE + h))
            tgt_o[h] <= field4[NCPU-1:0];
      end
   end

   // software interrupt destination decode
   always_comb begin
      for (int k = 0; k < NCPU; k++) self_m[k] = (wr_cpu == CPU_W'(k));
      case (smode)
         SM_LIST:   dest_m = field4[NCPU-1:0];
         SM_OTHERS: dest_m = ~self_m;
         SM_SELF:   dest_m = self_m;
         default:   dest_m = '0;
      endcase
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_sgi_c
      for (genvar s = 0; s < SGI_NUM; s++) begin : g_sgi_s
         assign sgi_set_o[c][s] = wr && (wr_addr == RA_SOFT) && dest_m[c] &&
                                  (wr_data[3:0] == 4'(s));
      end
   end
endmodule

// File: rtl/idc_state_cell.sv
module idc_state_cell #(
   parameter bit LEVEL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raise,
   input  logic       take,
   input  logic       done,
   output logic [1:0] st
);
   import idc_pkg::*;

   logic [1:0] st_n;

   always_comb begin
      st_n = st;
      case (st)
         ST_INACT: if (raise) st_n = ST_PEND;
         ST_PEND: begin
            if (take)                 st_n = ST_ACT;
            else if (LEVEL && !raise) st_n = ST_INACT;
         end
         ST_ACT:   if (done) st_n = ST_INACT;
         default:  st_n = ST_INACT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_INACT;
      else        st <= st_n;
   end
endmodule

// File: rtl/idc_arbiter.sv
module idc_arbiter #(
   parameter int NID = 40,
   localparam int IDW = idc_pkg::ID_W,
   localparam int PW  = idc_pkg::PRIO_W
) (
   input  logic [NID-1:0][1:0]    st,
   input  logic [NID-1:0]         en,
   input  logic [NID-1:0][PW-1:0] prio,
   input  logic [PW-1:0]          pmask,
   output logic                   hit,
   output logic [IDW-1:0]         win_id
);
   import idc_pkg::*;

   logic [PW:0] run;
   logic [PW:0] best;

   always_comb begin
      // running priority: most urgent active interrupt, none = 2**PW
      run = {1'b1, {PW{1'b0}}};
      for (int i = 0; i < NID; i++)
         if (st[i] == ST_ACT && {1'b0, prio[i]} < run) run = {1'b0, prio[i]};

      best   = {1'b1, {PW{1'b0}}};
      hit    = 1'b0;
      win_id = '0;
      // ascending scan with strict compare keeps the lowest ID on ties
      for (int i = 0; i < NID; i++) begin
         if (st[i] == ST_PEND && en[i] &&
             {1'b0, prio[i]} < {1'b0, pmask} &&
             {1'b0, prio[i]} < run &&
             {1'b0, prio[i]} < best) begin
            best   = {1'b0, prio[i]};
            hit    = 1'b1;
            win_id = IDW'(i);
         end
      end
   end
endmodule

// File: rtl/idc_distributor.sv
module idc_distributor #(
   parameter int NCPU   = 4,
   parameter int NUM_HW = 8,
   localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
   localparam int IDW   = idc_pkg::ID_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [CPU_W-1:0]      reg_cpu,
   input  logic [2:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   input  logic [NUM_HW-1:0]     hw_irq,
   input  logic [NCPU-1:0]       timer_irq,
   input  logic [NCPU-1:0]       wdog_irq,
   input  logic [NCPU-1:0]       ack_req,
   input  logic [NCPU-1:0]       eoi_req,
   input  logic [NCPU*IDW-1:0]   eoi_id,
   output logic [NCPU-1:0]       irq,
   output logic [NCPU*IDW-1:0]   ack_id
);
   import idc_pkg::*;

   localparam int NID = HW_BASE + NUM_HW;
   localparam int PW  = PRIO_W;

   if (NCPU < 1 || NCPU > 4) begin : g_bad_ncpu
      $error("idc_distributor: NCPU must be 1..4");
   end
   if (NUM_HW < 1 || NUM_HW > HW_MAX) begin : g_bad_hw
      $error("idc_distributor: NUM_HW must be 1..224");
   end

   logic [NCPU-1:0][NID-1:0]          en;
   logic [NCPU-1:0][NID-1:0][PW-1:0]  prio;
   logic [NUM_HW-1:0][NCPU-1:0]       tgt;
   logic [NCPU-1:0][PW-1:0]           pmask;
   logic [NCPU-1:0][SGI_NUM-1:0]      sgi_set;
   logic [NCPU-1:0][NID-1:0][1:0]     st_q;
   logic [NCPU-1:0][NID-1:0]          take;
   logic [NCPU-1:0][NID-1:0]          done;
   logic [NCPU-1:0]                   hit;
   logic [NCPU-1:0][IDW-1:0]          win_id;
   logic [NCPU-1:0][IDW-1:0]          ack_q;

   idc_cfg_regs #(.NCPU(NCPU), .NUM_HW(NUM_HW), .CPU_W(CPU_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .wr_cpu   (reg_cpu),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .en_o     (en),
      .prio_o   (prio),
      .tgt_o    (tgt),
      .mask_o   (pmask),
      .sgi_set_o(sgi_set)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      for (genvar i = 0; i < NID; i++) begin : g_id
         assign take[c][i] = ack_req[c] && hit[c] && (win_id[c] == IDW'(i));
         assign done[c][i] = eoi_req[c] && (eoi_id[c*IDW +: IDW] == IDW'(i));

         if (id_used(i, NUM_HW)) begin : g_live
            logic raise;
            if (i < SGI_NUM) begin : g_soft
               assign raise = sgi_set[c][i];
            end else if (i == ID_TIMER) begin : g_tmr
               assign raise = timer_irq[c];
            end else if (i == ID_WDOG) begin : g_wdg
               assign raise = wdog_irq[c];
            end else begin : g_hw
               assign raise = hw_irq[i-HW_BASE] && tgt[i-HW_BASE][c];
            end

            idc_state_cell #(.LEVEL(i >= SGI_NUM)) u_cell (
               .clk  (clk),
               .rst_n(rst_n),
               .raise(raise),
               .take (take[c][i]),
               .done (done[c][i]),
               .st   (st_q[c][i])
            );
         end else begin : g_none
            assign st_q[c][i] = ST_INACT;
         end
      end

      idc_arbiter #(.NID(NID)) u_arb (
         .st    (st_q[c]),
         .en    (en[c]),
         .prio  (prio[c]),
         .pmask (pmask[c]),
         .hit   (hit[c]),
         .win_id(win_id[c])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)
            ack_q[c] <= IDW'(NO_IRQ);
         else if (ack_req[c])
            ack_q[c] <= hit[c] ? win_id[c] : IDW'(NO_IRQ);
      end

      assign irq[c]                 = hit[c];
      assign ack_id[c*IDW +: IDW]   = ack_q[c];
   end
endmodule

// File: rtl/idc_distributor_chk.sv
module idc_distributor_chk #(
   parameter int NCPU = 4,
   parameter int NID  = 40,
   localparam int IDW = idc_pkg::ID_W,
   localparam int PW  = idc_pkg::PRIO_W
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NCPU-1:0]            ack_req,
   input logic [NCPU-1:0]            irq,
   input logic [NCPU*IDW-1:0]        ack_id,
   input logic [NCPU-1:0][PW-1:0]    pmask,
   input logic [NCPU-1:0][NID-1:0][1:0] st_q,
   input logic [NCPU-1:0][NID-1:0]   take,
   input logic [NCPU-1:0][NID-1:0]   done
);
   import idc_pkg::*;

   for (genvar c = 0; c < NCPU; c++) begin : g_c
      assert_idle_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_req[c] && !irq[c]) |=> (ack_id[c*IDW +: IDW] == IDW'(NO_IRQ)));

      assert_ack_gives_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_req[c] && irq[c]) |=> (ack_id[c*IDW +: IDW] < IDW'(NID)));

      assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (pmask[c] == '0) |-> !irq[c]);

      for (genvar i = 0; i < NID; i++) begin : g_i
         assert_active_via_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[c][i] != ST_ACT && !take[c][i]) |=> (st_q[c][i] != ST_ACT));

         assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[c][i] == ST_ACT && done[c][i]) |=> (st_q[c][i] == ST_INACT));

         assert_active_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[c][i] == ST_ACT && !done[c][i]) |=> (st_q[c][i] == ST_ACT));
      end
   end
endmodule

bind idc_distributor idc_distributor_chk #(.NCPU(NCPU), .NID(NID)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .ack_req(ack_req),
   .irq    (irq),
   .ack_id (ack_id),
   .pmask  (pmask),
   .st_q   (st_q),
   .take   (take),
   .done   (done)
);

// File: tb/idc_distributor_tb.sv
module idc_distributor_tb_top;
   localparam int NCPU   = 4;
   localparam int NUM_HW = 8;
   localparam int IDW    = 10;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                reg_wr;
   logic [1:0]          reg_cpu;
   logic [2:0]          reg_addr;
   logic [31:0]         reg_wdata;
   logic [NUM_HW-1:0]   hw_irq;
   logic [NCPU-1:0]     timer_irq, wdog_irq, ack_req, eoi_req;
   logic [NCPU*IDW-1:0] eoi_id;
   logic [NCPU-1:0]     irq;
   logic [NCPU*IDW-1:0] ack_id;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   idc_distributor #(.NCPU(NCPU), .NUM_HW(NUM_HW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_cpu(reg_cpu),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hw_irq(hw_irq),
      .timer_irq(timer_irq), .wdog_irq(wdog_irq), .ack_req(ack_req),
      .eoi_req(eoi_req), .eoi_id(eoi_id), .irq(irq), .ack_id(ack_id)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 1'b0; reg_cpu = '0; reg_addr = '0; reg_wdata = '0;
      hw_irq = '0; timer_irq = '0; wdog_irq = '0; ack_req = '0; eoi_req = '0; eoi_id = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_reg(input int cpu, input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_cpu = 2'(cpu); reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_en(input int cpu, input int id, input bit e);
      wr_reg(cpu, 3'd0, {e, 21'b0, 10'(id)});
   endtask
   task automatic set_prio(input int cpu, input int id, input int p);
      wr_reg(cpu, 3'd1, {12'b0, 4'(p), 6'b0, 10'(id)});
   endtask
   task automatic set_tgt(input int id, input logic [3:0] m);
      wr_reg(0, 3'd2, {12'b0, m, 6'b0, 10'(id)});
   endtask
   task automatic send_sgi(input int cpu, input int id, input logic [1:0] mode, input logic [3:0] lst);
      wr_reg(cpu, 3'd3, {6'b0, mode, 4'b0, lst, 12'b0, 4'(id)});
   endtask
   task automatic set_mask(input int cpu, input int p);
      wr_reg(cpu, 3'd4, {28'b0, 4'(p)});
   endtask
   task automatic hw_setup(input int id, input int p, input logic [3:0] m);
      set_en(0, id, 1'b1); set_prio(0, id, p); set_tgt(id, m);
   endtask

   task automatic do_ack(input int cpu, output int id);
      ack_req[cpu] = 1'b1;
      @(negedge clk);
      ack_req[cpu] = 1'b0;
      id = int'(ack_id[cpu*IDW +: IDW]);
   endtask

   task automatic do_eoi(input int cpu, input int id);
      eoi_id[cpu*IDW +: IDW] = 10'(id);
      eoi_req[cpu] = 1'b1;
      @(negedge clk);
      eoi_req[cpu] = 1'b0;
   endtask

   task automatic t_reset();
      int id;
      do_reset();
      check("R1 irq after reset", 32'(irq), 32'h0);
      for (int c = 0; c < NCPU; c++) begin
         do_ack(c, id);
         check("R1 idle ack", 32'(id), 32'd1023);
      end
   endtask

   task automatic t_route();
      int id;
      do_reset();
      for (int c = 0; c < NCPU; c++) set_mask(c, 15);
      hw_setup(33, 5, 4'b0101);
      hw_irq[1] = 1'b1; tick();
      check("R2 target mask routing", 32'(irq), 32'b0101);
      do_ack(2, id);
      check("R2 ack on targeted cpu", 32'(id), 32'd33);
      hw_irq[1] = 1'b0; tick();
      check("R10 dropped line clears pending", 32'(irq), 32'b0000);
   endtask

   task automatic sgi_prep();
      do_reset();
      for (int c = 0; c < NCPU; c++) begin
         set_mask(c, 15);
         set_en(c, 3, 1'b1);
      end
   endtask

   task automatic t_sgi_modes();
      sgi_prep();
      send_sgi(1, 3, 2'd1, 4'b0000);
      check("R3 all but sender", 32'(irq), 32'b1101);
      sgi_prep();
      send_sgi(2, 3, 2'd2, 4'b0000);
      check("R3 sender only", 32'(irq), 32'b0100);
      sgi_prep();
      send_sgi(0, 3, 2'd0, 4'b1010);
      check("R3 listed set", 32'(irq), 32'b1010);
      sgi_prep();
      send_sgi(0, 3, 2'd3, 4'b1111);
      check("R3 mode 3 ignored", 32'(irq), 32'b0000);
   endtask

   task automatic t_sgi_prio();
      int id;
      do_reset();
      set_mask(0, 8); set_mask(1, 8);
      set_en(0, 5, 1'b1); set_en(1, 5, 1'b1);
      set_prio(0, 5, 2); set_prio(1, 5, 9); set_prio(3, 5, 15);
      send_sgi(3, 5, 2'd0, 4'b0011);
      check("R4 target cpu priority", 32'(irq), 32'b0001);
      do_ack(0, id);
      check("R4 ack of soft id", 32'(id), 32'd5);
   endtask

   task automatic t_select();
      int id;
      do_reset();
      set_mask(0, 15);
      hw_setup(33, 6, 4'b0001); hw_setup(34, 4, 4'b0001); hw_setup(35, 4, 4'b0001);
      hw_irq[3:1] = 3'b111; tick();
      do_ack(0, id);
      check("R5 lowest value then lowest id", 32'(id), 32'd34);
      check("R8 equal priority no preempt", 32'(irq[0]), 32'd0);
      do_ack(0, id);
      check("R7 nothing above running", 32'(id), 32'd1023);
   endtask

   task automatic t_mask();
      int id;
      do_reset();
      set_mask(3, 7);
      hw_setup(36, 7, 4'b1000);
      hw_irq[4] = 1'b1; tick();
      check("R6 equal to mask blocked", 32'(irq[3]), 32'd0);
      do_ack(3, id);
      check("R6 blocked ack spurious", 32'(id), 32'd1023);
      set_mask(3, 8);
      check("R6 below mask signalled", 32'(irq[3]), 32'd1);
   endtask

   task automatic t_nest();
      int id;
      do_reset();
      set_mask(0, 15);
      hw_setup(33, 8, 4'b0001); hw_setup(34, 8, 4'b0001); hw_setup(35, 3, 4'b0001);
      hw_irq[1] = 1'b1; tick();
      do_ack(0, id);
      check("R7 ack returns id", 32'(id), 32'd33);
      hw_irq[2] = 1'b1; tick();
      check("R8 same priority held off", 32'(irq[0]), 32'd0);
      hw_irq[3] = 1'b1; tick();
      check("R8 higher priority preempts", 32'(irq[0]), 32'd1);
      do_ack(0, id);
      check("R8 preempting id", 32'(id), 32'd35);
      hw_irq[3] = 1'b0;
      do_eoi(0, 35);
      check("R9 running back to outer", 32'(irq[0]), 32'd0);
      do_eoi(0, 33);
      check("R9 running priority released", 32'(irq[0]), 32'd1);
      tick();
      do_ack(0, id);
      check("R10 re-pended level wins tie", 32'(id), 32'd33);
   endtask

   task automatic t_eoi_cpu();
      int id;
      do_reset();
      set_mask(0, 15); set_mask(1, 15);
      hw_setup(37, 5, 4'b0011);
      hw_irq[5] = 1'b1; tick();
      do_ack(0, id);
      check("R7 cpu0 ack", 32'(id), 32'd37);
      do_ack(1, id);
      check("R7 cpu1 ack", 32'(id), 32'd37);
      check("R7 both active", 32'(irq[1:0]), 32'b00);
      do_eoi(0, 37);
      tick();
      check("R9 eoi only on issuing cpu", 32'(irq[1:0]), 32'b01);
   endtask

   task automatic t_private();
      int id;
      do_reset();
      for (int c = 0; c < NCPU; c++) set_mask(c, 15);
      set_en(2, 29, 1'b1); set_prio(2, 29, 1);
      timer_irq[2] = 1'b1; wdog_irq[1] = 1'b1; tick();
      check("R11 timer on own cpu, R12 wdog disabled", 32'(irq), 32'b0100);
      set_en(1, 30, 1'b1);
      check("R12 enable releases pending", 32'(irq), 32'b0110);
      do_ack(2, id);
      check("R11 timer id", 32'(id), 32'd29);
      do_ack(1, id);
      check("R11 watchdog id", 32'(id), 32'd30);
   endtask

   initial begin
      rst_n = 1'b0;
      t_reset();
      t_route();
      t_sgi_modes();
      t_sgi_prio();
      t_select();
      t_mask();
      t_nest();
      t_eoi_cpu();
      t_private();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule